// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page table entries from memory, one per level. A requester presents the virtual address, the kind of access (read, write or execute) and whether the access comes from user or kernel mode. The walker then reads the first-level entry, located from a table base input, and the second-level entry, located through the frame held in the first-level entry. It answers with the physical address or with a fault code and the level at which the walk stopped.

Memory is reached through a plain read port: the walker raises a one-cycle request with a byte address and waits, for any number of cycles, for a data-valid pulse. Only one walk runs at a time. A busy flag covers the walk from acceptance up to and including the response cycle. The 12-bit page offset is carried into the physical address untouched.

Top module: `pgw_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy_o, mem_req_o and rsp_valid_o are low.
- R2: With busy_o low, req_valid_i high is accepted at the clock edge, and busy_o is high from the next cycle until the response cycle. A request presented while busy_o is high is ignored and starts no memory read.
- R3: The first memory read is a one-cycle mem_req_o pulse with mem_addr_o = ptbr_i + vaddr[31:22] * 4. ptbr_i is sampled when the request is accepted.
- R4: When the first entry has bit 0 (valid) set, a second one-cycle read follows with mem_addr_o = {entry[31:12], 12'h000} + vaddr[21:12] * 4. Bits 1 to 4 of the first entry are not checked.
- R5: A first-level entry with bit 0 clear ends the walk with rsp_fault_o = 1 (not present) and rsp_level_o = 1, and no second read is issued.
- R6: A second-level entry with bit 0 clear gives rsp_fault_o = 1 and rsp_level_o = 2.
- R7: Access codes on req_acc_i are 0 read, 1 write, 2 execute and 3 reserved. A valid second-level entry allows the access only if bit 1 is set for a read, bit 2 for a write and bit 3 for an execute. Code 3 is never allowed. A denied access gives rsp_fault_o = 2 (protection) and rsp_level_o = 2.
- R8: A user-mode access (req_user_i = 1) is denied with rsp_fault_o = 2 when bit 4 of the second-level entry is clear. A kernel-mode access does not depend on bit 4.
- R9: On success, rsp_fault_o = 0, rsp_level_o = 0 and rsp_paddr_o = {entry[31:12], vaddr[11:0]}. On any fault, rsp_paddr_o = 0.
- R10: rsp_valid_o is high for exactly one cycle, the cycle after the read data that ends the walk arrives. busy_o is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr_i | input | 32 | Byte address of the first-level table |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_user_i | input | 1 | 1 for user mode, 0 for kernel mode |
| busy_o | output | 1 | A walk is in progress |
| mem_req_o | output | 1 | One-cycle entry read request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_paddr_o | output | 32 | Physical address, zero on a fault |
| rsp_fault_o | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_level_o | output | 2 | Level of the fault, 1 or 2; 0 on success |

## Verification
The bench builds the block with its default parameters: 32-bit addresses split 10/10/12. At these sizes the table indices, the frame fields and the offset fall on the same bit positions that the bench's behavioural memory model computes independently. Memory latency rotates from one to three cycles between reads, so the data can arrive in the first wait cycle or later in both walk levels. Stray requests held during a walk, and back-to-back walks that share a second-level table, cover the acceptance and ignore cases.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ1  = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_REQ2  = 3'd3,
        ST_WAIT2 = 3'd4,
        ST_RESP  = 3'd5
    } walk_st_e;

    localparam int PTE_V = 0;
    localparam int PTE_R = 1;
    localparam int PTE_W = 2;
    localparam int PTE_X = 3;
    localparam int PTE_U = 4;

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10,
    parameter int PTE_BYTES = 4
) (
    input  logic             second_i,
    input  logic [VA_W-1:0]  base_i,
    input  logic [VA_W-1:0]  va_i,
    output logic [VA_W-1:0]  addr_o
);
    localparam int TOP_W = VA_W - OFF_W - IDX_W;
    localparam int SHIFT = $clog2(PTE_BYTES);

    logic [VA_W-1:0] idx_lvl [2];

    genvar gl;
    generate
        for (gl = 0; gl < 2; gl++) begin : g_lvl
            if (gl == 0) begin : g_top
                assign idx_lvl[gl] = {{(VA_W-TOP_W){1'b0}}, va_i[VA_W-1 -: TOP_W]};
            end else begin : g_mid
                assign idx_lvl[gl] = {{(VA_W-IDX_W){1'b0}}, va_i[OFF_W +: IDX_W]};
            end
        end
    endgenerate

    logic [VA_W-1:0] idx_sel;
    always_comb begin
        idx_sel = second_i ? idx_lvl[1] : idx_lvl[0];
        addr_o  = base_i + (idx_sel << SHIFT);
    end

endmodule

// File: rtl/pgw_rights.sv
module pgw_rights
    import pgw_pkg::*;
#(
    parameter int PTE_WD = 32
) (
    input  logic [PTE_WD-1:0] pte_i,
    input  acc_e              acc_i,
    input  logic              user_i,
    output logic              allow_o
);
    logic kind_ok;
    always_comb begin
        unique case (acc_i)
            ACC_READ:  kind_ok = pte_i[PTE_R];
            ACC_WRITE: kind_ok = pte_i[PTE_W];
            ACC_EXEC:  kind_ok = pte_i[PTE_X];
            default:   kind_ok = 1'b0;
        endcase
        allow_o = kind_ok && (!user_i || pte_i[PTE_U]);
    end

endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] ptbr_i,
    input  logic            req_valid_i,
    input  logic [VA_W-1:0] req_vaddr_i,
    input  logic [1:0]      req_acc_i,
    input  logic            req_user_i,
    output logic            busy_o,
    output logic            mem_req_o,
    output logic [VA_W-1:0] mem_addr_o,
    input  logic            mem_rvalid_i,
    input  logic [VA_W-1:0] mem_rdata_i,
    output logic            rsp_valid_o,
    output logic [VA_W-1:0] rsp_paddr_o,
    output logic [1:0]      rsp_fault_o,
    output logic [1:0]      rsp_level_o
);
    localparam int FRAME_W = VA_W - OFF_W;

    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] va;
        acc_e            acc;
        logic            user;
        logic [VA_W-1:0] base;
        logic [VA_W-1:0] paddr;
        flt_e            flt;
        logic [1:0]      lvl;
    } walk_t;

    walk_t w_q, w_d;
    logic [VA_W-1:0] pte_addr;
    logic            allow;

    pgw_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_BYTES(4)) u_agen (
        .second_i (w_q.st == ST_REQ2),
        .base_i   (w_q.base),
        .va_i     (w_q.va),
        .addr_o   (pte_addr)
    );

    pgw_rights #(.PTE_WD(VA_W)) u_rights (
        .pte_i   (mem_rdata_i),
        .acc_i   (w_q.acc),
        .user_i  (w_q.user),
        .allow_o (allow)
    );

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    w_d.st    = ST_REQ1;
                    w_d.va    = req_vaddr_i;
                    w_d.acc   = acc_e'(req_acc_i);
                    w_d.user  = req_user_i;
                    w_d.base  = ptbr_i;
                    w_d.paddr = '0;
                    w_d.flt   = FLT_NONE;
                    w_d.lvl   = 2'd0;
                end
            end
            ST_REQ1: w_d.st = ST_WAIT1;
            ST_WAIT1: begin
                if (mem_rvalid_i) begin
                    if (!mem_rdata_i[PTE_V]) begin
                        w_d.st  = ST_RESP;
                        w_d.flt = FLT_ABSENT;
                        w_d.lvl = 2'd1;
                    end else begin
                        w_d.st   = ST_REQ2;
                        w_d.base = {mem_rdata_i[VA_W-1:OFF_W], {OFF_W{1'b0}}};
                    end
                end
            end
            ST_REQ2: w_d.st = ST_WAIT2;
            ST_WAIT2: begin
                if (mem_rvalid_i) begin
                    w_d.st = ST_RESP;
                    if (!mem_rdata_i[PTE_V]) begin
                        w_d.flt = FLT_ABSENT;
                        w_d.lvl = 2'd2;
                    end else if (!allow) begin
                        w_d.flt = FLT_PROT;
                        w_d.lvl = 2'd2;
                    end else begin
                        w_d.paddr = {mem_rdata_i[VA_W-1 -: FRAME_W], w_q.va[OFF_W-1:0]};
                    end
                end
            end
            ST_RESP: w_d.st = ST_IDLE;
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: ST_IDLE, va: '0, acc: ACC_READ, user: 1'b0, base: '0,
                     paddr: '0, flt: FLT_NONE, lvl: 2'd0};
        end else begin
            w_q <= w_d;
        end
    end

    assign busy_o      = (w_q.st != ST_IDLE);
    assign mem_req_o   = (w_q.st == ST_REQ1) || (w_q.st == ST_REQ2);
    assign mem_addr_o  = pte_addr;
    assign rsp_valid_o = (w_q.st == ST_RESP);
    assign rsp_paddr_o = w_q.paddr;
    assign rsp_fault_o = w_q.flt;
    assign rsp_level_o = w_q.lvl;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid_i) |=> busy_o); // R2
    AST_MREQ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o); // R3
    AST_MREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o); // R3
    AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o != 2'd0) |-> (rsp_level_o == 2'd1 || rsp_level_o == 2'd2)); // R5
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o != 2'd0) |-> (rsp_paddr_o == '0)); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> (!rsp_valid_o && !busy_o)); // R10
    AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid_o) |-> $past(mem_rvalid_i)); // R10

endmodule

// File: tb/sim_pgw_top.sv
module sim_pgw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ptbr_i = 32'h0010_0000;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_vaddr_i = '0;
    logic [1:0]  req_acc_i = '0;
    logic        req_user_i = 1'b0;
    logic        busy_o, mem_req_o, rsp_valid_o;
    logic [31:0] mem_addr_o, rsp_paddr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic [1:0]  rsp_fault_o, rsp_level_o;

    pgw_top u0 (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    logic [31:0] mem [logic [31:0]];

    // stimulus request
    logic        s_valid = 0;
    logic [31:0] s_va = 0;
    logic [1:0]  s_acc = 0;
    logic        s_user = 0;
    // model
    logic        m_busy = 0, m_rsp = 0;
    logic [31:0] e_addr [2];
    int          e_nrd = 0, rd_n = 0;
    logic [31:0] e_pa;
    logic [1:0]  e_flt, e_lvl;
    // memory responder
    logic        pend = 0;
    logic [31:0] pend_addr = 0;
    int          pend_cnt = 0, lat_rot = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic predict(input logic [31:0] va, input logic [1:0] acc, input logic usr, input logic [31:0] base);
        logic [31:0] p1, p2;
        bit ok;
        rd_n = 0;
        e_pa = 0;
        e_addr[0] = base + 32'(va[31:22]) * 4;
        p1 = rd(e_addr[0]);
        if (!p1[0]) begin
            e_nrd = 1; e_flt = 2'd1; e_lvl = 2'd1;
            return;
        end
        e_addr[1] = {p1[31:12], 12'h000} + 32'(va[21:12]) * 4;
        p2 = rd(e_addr[1]);
        e_nrd = 2;
        if (!p2[0]) begin
            e_flt = 2'd1; e_lvl = 2'd2;
            return;
        end
        ok = (acc == 2'd0 && p2[1]) || (acc == 2'd1 && p2[2]) || (acc == 2'd2 && p2[3]);
        if (usr && !p2[4]) ok = 0;
        if (ok) begin
            e_flt = 0; e_lvl = 0; e_pa = {p2[31:12], va[11:0]};
        end else begin
            e_flt = 2'd2; e_lvl = 2'd2;
        end
    endtask

    task automatic tick();
        bit was_idle;
        @(negedge clk);
        cyc++;
        chk(busy_o == m_busy, "R2 busy_o", 32'(busy_o), 32'(m_busy));
        chk(rsp_valid_o == m_rsp, "R10 rsp_valid_o", 32'(rsp_valid_o), 32'(m_rsp));
        if (m_rsp && rsp_valid_o) begin
            chk(rsp_fault_o == e_flt, "R5/R6/R7/R8 rsp_fault_o", 32'(rsp_fault_o), 32'(e_flt));
            chk(rsp_level_o == e_lvl, "R5/R6 rsp_level_o", 32'(rsp_level_o), 32'(e_lvl));
            chk(rsp_paddr_o == e_pa, "R9 rsp_paddr_o", rsp_paddr_o, e_pa);
        end
        was_idle = !m_busy;
        mem_rvalid_i = 0;
        if (m_rsp) begin
            m_rsp = 0; m_busy = 0;
        end else if (pend) begin
            if (pend_cnt <= 1) begin
                mem_rvalid_i = 1;
                mem_rdata_i = rd(pend_addr);
                pend = 0;
                if (rd_n == e_nrd) m_rsp = 1;
            end else pend_cnt--;
        end
        if (mem_req_o) begin
            chk(m_busy && !pend && rd_n < e_nrd, "R2/R5 unexpected mem_req_o", 32'(rd_n), 32'(e_nrd));
            if (rd_n < 2)
                chk(mem_addr_o == e_addr[rd_n], rd_n == 0 ? "R3 first address" : "R4 second address",
                    mem_addr_o, e_addr[rd_n]);
            pend = 1; pend_addr = mem_addr_o;
            pend_cnt = 1 + lat_rot % 3; lat_rot++;
            rd_n++;
        end
        req_valid_i = s_valid; req_vaddr_i = s_va; req_acc_i = s_acc; req_user_i = s_user;
        if (was_idle && s_valid) begin
            m_busy = 1;
            predict(s_va, s_acc, s_user, ptbr_i);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr, input bit noise);
        s_valid = 1; s_va = va; s_acc = acc; s_user = usr;
        tick();
        s_valid = 0;
        while (m_busy) begin
            s_valid = noise && !m_rsp;
            s_va = 32'hFFC0_0ABC; s_acc = 2'd0; s_user = 0;
            tick();
        end
        s_valid = 0;
        tick();
    endtask

    task automatic map(input logic [31:0] va, input logic [19:0] l2frame, input logic [31:0] leaf);
        mem[ptbr_i + 32'(va[31:22]) * 4] = {l2frame, 12'h001};
        mem[{l2frame, 12'h000} + 32'(va[21:12]) * 4] = leaf;
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk(!busy_o && !mem_req_o && !rsp_valid_o, "R1 reset outputs",
                {29'b0, busy_o, mem_req_o, rsp_valid_o}, 32'h0);
        end
        rst_n = 1;
        tick();
        chk(!busy_o && !mem_req_o && !rsp_valid_o, "R1 after release",
            {29'b0, busy_o, mem_req_o, rsp_valid_o}, 32'h0);

        // R9 kernel read of a read-write page, offset passes through
        map(32'h0040_3ABC, 20'h00200, {20'hABCDE, 12'h007});
        walk(32'h0040_3ABC, 2'd0, 0, 0);
        // R7 write to a read-only user page -> protection
        map(32'h0040_4123, 20'h00200, {20'h12345, 12'h013});
        walk(32'h0040_4123, 2'd1, 1, 0);
        // R7 read of same page as user -> ok
        walk(32'h0040_4FFF, 2'd0, 1, 0);
        // R7 execute on execute-only page
        map(32'h8000_0000, 20'h00300, {20'h0BEEF, 12'h019});
        walk(32'h8000_0000, 2'd2, 1, 0);
        // R7 read of execute-only page denied
        walk(32'h8000_0010, 2'd0, 0, 0);
        // R7 reserved access code always denied
        walk(32'h8000_0020, 2'd3, 0, 0);
        // R8 user access to kernel-only page denied, kernel allowed
        map(32'hC012_3456, 20'h00400, {20'hFEDCB, 12'h00F});
        walk(32'hC012_3456, 2'd1, 1, 0);
        walk(32'hC012_3456, 2'd1, 0, 0);
        // R5 first-level entry absent
        walk(32'h7FC0_0000, 2'd0, 0, 0);
        // R6 second-level entry absent
        map(32'h0080_5000, 20'h00500, {20'h11111, 12'h016});
        walk(32'h0080_6000, 2'd0, 0, 0);
        // R4 first-level entry without permission bits still walks
        mem[ptbr_i + 32'(10'h3FF) * 4] = {20'h00600, 12'h001};
        mem[{20'h00600, 12'h000} + 32'(10'h3FF) * 4] = {20'h00042, 12'h003};
        walk(32'hFFFF_F001, 2'd0, 0, 0);
        // R2 requests held during a walk are ignored
        walk(32'h0040_3ABC, 2'd0, 0, 1);
        walk(32'h7FC0_0000, 2'd0, 0, 1);
        // R3 new table base
        ptbr_i = 32'h0020_0000;
        map(32'h0000_1234, 20'h00700, {20'h55555, 12'h003});
        walk(32'h0000_1234, 2'd0, 0, 0);
        repeat (3) tick();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule